// File: doc/BRIEF.md
# Programmable-Depth Convolutional Byte Interleaver

This block spreads a byte stream over time before it is sent, so that a burst of line errors is broken up into isolated byte errors once a matching deinterleaver puts the bytes back in order. Incoming bytes are dealt to 33 branches in strict rotation, with one byte going to each branch in turn. Branch `k` holds its bytes for `M*k` of its own visits, and the branch outputs are merged back in the same rotation. The depth `M` is set at run time. A depth of zero makes the block a plain pass-through.

All the branch delay lines sit in one synchronous RAM. Each line is a circular buffer, and its base address is the running total of the lengths of the lines below it. The commutator builds that base one branch at a time by additions, so no multiplier is needed. Each branch keeps its own read/write offset, and the offset moves once per visit to that branch. A new depth takes effect only on a byte that starts both a coded block and a frame. When the depth changes, all offsets are cleared and the stored bytes are taken as stale until they have been overwritten. Every output is registered, which gives one pipeline stage in all modes.

Top module: `cvi_interleaver`

## Requirements
- R1: The byte that has `in_blk_start` high is routed to branch 0. Each later valid byte goes to the next branch, and branch 32 wraps to branch 0. `out_blk_start` is high with the output byte that belongs to the block-start input byte.
- R2: With active depth M > 0, a byte that enters branch k on visit v of that branch leaves on visit v + M*k of that branch. It appears on the output in the cycle after that visit.
- R3: Branch 0 adds no interleaving delay. Its byte appears on `out_data` in the cycle after it was accepted, at any depth.
- R4: With active depth 0, `out_data` in each valid output cycle equals the `in_data` of the previous cycle.
- R5: When the output is passed through a matching deinterleaver, where branch k delays by M*(32-k) visits, the input stream is recovered bit-exact 1056*M valid byte periods later.
- R6: `cfg_depth` is loaded only on a valid byte that has both `in_blk_start` and `in_frm_start` high. At all other times its value has no effect. A reload with the same value leaves the stored bytes and offsets untouched. A reload with a different value clears every branch offset.
- R7: After reset the active depth is 0, so the block passes bytes through, and `out_valid` is low until a byte has been accepted.
- R8: `out_valid` is `in_valid` delayed by exactly one cycle. Idle cycles do not advance the commutator or any branch offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | DEP_W | Requested interleaving depth M (0 to MAX_DEPTH) |
| in_valid | input | 1 | Input byte strobe |
| in_blk_start | input | 1 | First byte of a coded block (aligns the commutator to branch 0) |
| in_frm_start | input | 1 | Frame boundary, taken as such only together with in_blk_start |
| in_data | input | DATA_W | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_blk_start | output | 1 | Output byte belongs to branch 0 of a block start |
| out_data | output | DATA_W | Interleaved output byte |

## Verification
The bound checker checks on every cycle that the valid strobe and block marker follow the input by one cycle. It also checks that branch-0 bytes and all bytes in bypass pass straight through, that the active depth changes only at a frame-start byte, and that every RAM access stays inside the computed buffer space. The per-branch delay of M*k visits, the 1056*M end-to-end latency through a deinterleaver, and the retention of stored bytes across same-depth reloads depend on long histories. Only the bench scenarios can show these. They use random data with idle gaps and random `cfg_depth` noise away from frame starts, at depths 0, 1, 5, 31 and 2, with the last reached by a change from 31.

// File: rtl/cvi_pkg.sv
// Shared constants and helpers for the convolutional interleaver.
// Assumes: branch count and depth limits are small positive integers.
package cvi_pkg;

    localparam int unsigned CVI_BRANCHES = 33;
    localparam int unsigned CVI_DATA_W   = 8;

    // Number of bytes needed by all branch lines at a given depth.
    function automatic int unsigned cvi_ram_bytes(input int unsigned branches,
                                                  input int unsigned depth);
        return depth * branches * (branches - 1) / 2;
    endfunction

endpackage

// File: rtl/cvi_commutator.sv
// Branch commutator and depth register.
// Tracks the branch about to be visited. Builds the base address and line
// length of that branch by running sums (base += len, len += M), so no
// multiplier is needed. Takes a new depth only on a frame-start byte.
// Assumes: frame starts coincide with block starts; at most one byte per cycle.
module cvi_commutator #(
    parameter int unsigned BRANCHES = 33,
    parameter int unsigned BR_W     = 6,
    parameter int unsigned DEP_W    = 5,
    parameter int unsigned SIZE_W   = 10,
    parameter int unsigned ADDR_W   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_blk_start,
    input  logic              in_frm_start,
    input  logic [DEP_W-1:0]  cfg_depth,
    output logic [BR_W-1:0]   cur_branch,
    output logic [ADDR_W-1:0] cur_base,
    output logic [SIZE_W-1:0] cur_size,
    output logic [DEP_W-1:0]  eff_depth,
    output logic              ptr_clear
);

    localparam logic [BR_W-1:0] LAST_BR = BR_W'(BRANCHES - 1);

    logic [BR_W-1:0]   br_q;
    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    logic [DEP_W-1:0]  depth_q;
    logic              load;
    logic              first;

    // Select the branch, base, length and depth that apply to the current byte.
    always_comb begin
        load       = in_valid && in_blk_start && in_frm_start;
        eff_depth  = load ? cfg_depth : depth_q;
        ptr_clear  = load && (cfg_depth != depth_q);
        cur_branch = in_blk_start ? '0 : br_q;
        first      = (cur_branch == '0);
        cur_base   = first ? '0 : base_q;
        cur_size   = first ? '0 : size_q;
    end

    // Advance the rotation and the running sums once per accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_q    <= '0;
            base_q  <= '0;
            size_q  <= '0;
            depth_q <= '0;
        end else if (in_valid) begin
            depth_q <= eff_depth;
            br_q    <= (cur_branch == LAST_BR) ? '0 : cur_branch + 1'b1;
            base_q  <= cur_base + ADDR_W'(cur_size);
            size_q  <= cur_size + SIZE_W'(eff_depth);
        end
    end

endmodule

// File: rtl/cvi_ptr_bank.sv
// Per-branch circular-buffer offsets.
// Branch 0 has no line and its offset stays zero. Every other offset moves
// forward on a visit and wraps at the current line length.
// Assumes: cur_size equals depth*branch for the visited branch.
module cvi_ptr_bank #(
    parameter int unsigned BRANCHES = 33,
    parameter int unsigned BR_W     = 6,
    parameter int unsigned SIZE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              adv,
    input  logic [BR_W-1:0]   cur_branch,
    input  logic [SIZE_W-1:0] cur_size,
    output logic [SIZE_W-1:0] cur_ptr
);

    logic [SIZE_W-1:0] ptr_w [BRANCHES];

    for (genvar k = 0; k < BRANCHES; k++) begin : g_br
        if (k == 0) begin : g_zero
            assign ptr_w[k] = '0;
        end else begin : g_line
            logic [SIZE_W-1:0] ptr_q;
            logic [SIZE_W-1:0] ptr_inc;
            assign ptr_inc = ptr_q + 1'b1;
            // Move this branch's offset on its visit, wrapping at the line length.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    ptr_q <= '0;
                end else if (adv && (cur_branch == BR_W'(k))) begin
                    ptr_q <= (ptr_inc == cur_size) ? '0 : ptr_inc;
                end
            end
            assign ptr_w[k] = ptr_q;
        end
    end

    assign cur_ptr = ptr_w[cur_branch];

endmodule

// File: rtl/cvi_delay_ram.sv
// Single-port synchronous RAM with read-before-write.
// One access per cycle returns the byte stored at that address and then
// replaces it. This is one step of a circular delay line.
// Assumes: addr < DEPTH whenever en is high.
module cvi_delay_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3696,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Read the old byte and store the new one at the same address.
    always_ff @(posedge clk) begin
        if (en) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/cvi_interleaver.sv
// Convolutional byte interleaver with a run-time depth.
// Bytes are dealt over BRANCHES branches, and branch k delays by depth*k of
// its visits. All lines share one RAM. Branch 0 and depth 0 take a register
// bypass. Outputs are registered with one cycle of latency.
// Assumes: blocks are a multiple of BRANCHES bytes long; cfg_depth <= MAX_DEPTH.
module cvi_interleaver
    import cvi_pkg::*;
#(
    parameter int unsigned DATA_W    = CVI_DATA_W,
    parameter int unsigned BRANCHES  = CVI_BRANCHES,
    parameter int unsigned MAX_DEPTH = 7,
    localparam int unsigned DEP_W    = $clog2(MAX_DEPTH + 1),
    localparam int unsigned BR_W     = $clog2(BRANCHES),
    localparam int unsigned SIZE_W   = $clog2(MAX_DEPTH * BRANCHES + 1),
    localparam int unsigned MEM_DEPTH = cvi_ram_bytes(BRANCHES, MAX_DEPTH),
    localparam int unsigned ADDR_W   = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEP_W-1:0]  cfg_depth,
    input  logic              in_valid,
    input  logic              in_blk_start,
    input  logic              in_frm_start,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_blk_start,
    output logic [DATA_W-1:0] out_data
);

    logic [BR_W-1:0]   cur_branch;
    logic [ADDR_W-1:0] cur_base;
    logic [SIZE_W-1:0] cur_size;
    logic [SIZE_W-1:0] cur_ptr;
    logic [DEP_W-1:0]  eff_depth;
    logic              ptr_clear;
    logic              pass;
    logic              ram_en;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_rd;
    logic              vld_q;
    logic              sob_q;
    logic              pass_q;
    logic [DATA_W-1:0] din_q;

    cvi_commutator #(
        .BRANCHES(BRANCHES), .BR_W(BR_W), .DEP_W(DEP_W),
        .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)
    ) u_comm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_blk_start(in_blk_start), .in_frm_start(in_frm_start),
        .cfg_depth(cfg_depth), .cur_branch(cur_branch), .cur_base(cur_base),
        .cur_size(cur_size), .eff_depth(eff_depth), .ptr_clear(ptr_clear)
    );

    cvi_ptr_bank #(
        .BRANCHES(BRANCHES), .BR_W(BR_W), .SIZE_W(SIZE_W)
    ) u_ptrs (
        .clk(clk), .rst_n(rst_n), .clear(ptr_clear), .adv(ram_en),
        .cur_branch(cur_branch), .cur_size(cur_size), .cur_ptr(cur_ptr)
    );

    // Pick the bypass path or form the RAM address for a delayed branch.
    always_comb begin
        pass     = (eff_depth == '0) || (cur_branch == '0);
        ram_en   = in_valid && !pass;
        ram_addr = cur_base + ADDR_W'(cur_ptr);
    end

    cvi_delay_ram #(
        .DATA_W(DATA_W), .DEPTH(MEM_DEPTH), .ADDR_W(ADDR_W)
    ) u_ram (
        .clk(clk), .en(ram_en), .addr(ram_addr), .wdata(in_data), .rdata(ram_rd)
    );

    // Output stage: strobes and the bypass byte, aligned with the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            sob_q  <= 1'b0;
            pass_q <= 1'b1;
            din_q  <= '0;
        end else begin
            vld_q <= in_valid;
            sob_q <= in_valid && in_blk_start;
            if (in_valid) begin
                pass_q <= pass;
                din_q  <= in_data;
            end
        end
    end

    assign out_valid     = vld_q;
    assign out_blk_start = sob_q;
    assign out_data      = pass_q ? din_q : ram_rd;

endmodule

// File: rtl/cvi_interleaver_chk.sv
// Cycle-level checks for cvi_interleaver, attached by bind.
// Assumes: connected to the top's ports and a few internal nets.
module cvi_interleaver_chk #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DEP_W     = 3,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned MEM_DEPTH = 3696
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_blk_start,
    input logic              in_frm_start,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_blk_start,
    input logic [DATA_W-1:0] out_data,
    input logic [DEP_W-1:0]  eff_depth,
    input logic              ram_en,
    input logic [ADDR_W-1:0] ram_addr
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R8
    AST_SOB_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_blk_start) |=> out_blk_start); // R1
    AST_BRANCH0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_blk_start) |=> (out_data == $past(in_data))); // R3
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && eff_depth == '0) |=> (out_data == $past(in_data))); // R4
    AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !(in_valid && in_blk_start && in_frm_start))
            |-> $stable(eff_depth)); // R6
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> ({1'b0, ram_addr} < (ADDR_W + 1)'(MEM_DEPTH))); // R2

endmodule

bind cvi_interleaver cvi_interleaver_chk #(
    .DATA_W(DATA_W), .DEP_W(DEP_W), .ADDR_W(ADDR_W), .MEM_DEPTH(MEM_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blk_start(in_blk_start),
    .in_frm_start(in_frm_start), .in_data(in_data), .out_valid(out_valid),
    .out_blk_start(out_blk_start), .out_data(out_data), .eff_depth(eff_depth),
    .ram_en(ram_en), .ram_addr(ram_addr)
);

// File: tb/tb_cvi_interleaver.sv
// Bench: random bytes with idle gaps and depth noise, plus directed depths
// 0, 1, 5, 31 and 2. Expected values come from index arithmetic on
// recorded streams and from a behavioural deinterleaver.
module tb_cvi_interleaver;

    localparam int MAXD = 31;
    localparam int NBR  = 33;
    localparam int HMAX = 36000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_depth = '0;
    logic       in_valid = 1'b0;
    logic       in_blk_start = 1'b0;
    logic       in_frm_start = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_blk_start;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    int oc = 0;
    int sob_bad = 0;
    bit cap_en = 1'b0;
    logic [7:0] in_h  [HMAX];
    logic [7:0] out_h [HMAX];

    cvi_interleaver #(.DATA_W(8), .BRANCHES(NBR), .MAX_DEPTH(MAXD)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .in_valid(in_valid),
        .in_blk_start(in_blk_start), .in_frm_start(in_frm_start),
        .in_data(in_data), .out_valid(out_valid),
        .out_blk_start(out_blk_start), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // Record output bytes and block marks away from the active edge.
    always @(negedge clk) begin
        if (cap_en && out_valid) begin
            if (oc < HMAX) out_h[oc] = out_data;
            if (out_blk_start != ((oc % 66) == 0)) sob_bad++;
            oc++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; in_blk_start = 1'b0; in_frm_start = 1'b0;
        in_data = 8'($urandom);
    endtask

    // Feed n bytes at depth m, then compare against the expected streams.
    task automatic run(input int m, input int n, input int gap_pct,
                       input bit load, input bit noise);
        int bad2, a2, e2, bad3, a3, e3, bad5, a5, e5;
        oc = 0; sob_bad = 0; cap_en = 1'b1;
        bad2 = 0; bad3 = 0; bad5 = 0; a2 = 0; e2 = 0; a3 = 0; e3 = 0; a5 = 0; e5 = 0;
        for (int i = 0; i < n; i++) begin
            bit blk;
            if (($urandom % 100) < gap_pct) idle();
            blk = (i % 66) == 0;
            @(posedge clk); #1;
            in_valid     = 1'b1;
            in_blk_start = blk;
            in_frm_start = blk && load && ((i % 792) == 0);
            cfg_depth    = in_frm_start ? 5'(m) : (noise ? 5'($urandom) : 5'(m));
            in_data      = 8'($urandom);
            in_h[i]      = in_data;
        end
        repeat (3) idle();
        @(negedge clk); #1;
        cap_en = 1'b0;
        chk(oc == n, "R8", "output byte count", oc, n);
        chk(sob_bad == 0, "R1", "block mark misplaced", sob_bad, 0);
        for (int i = 0; i < n; i++) begin
            int k, d, j;
            k = i % NBR;
            d = NBR * m * k;
            if (k == 0 && out_h[i] !== in_h[i]) begin
                if (bad3 == 0) begin a3 = out_h[i]; e3 = in_h[i]; end
                bad3++;
            end
            if (i >= d && out_h[i] !== in_h[i-d]) begin
                if (bad2 == 0) begin a2 = out_h[i]; e2 = in_h[i-d]; end
                bad2++;
            end
            if (i >= 1056 * m) begin
                j = i - NBR * m * (32 - k);
                if (out_h[j] !== in_h[i - 1056 * m]) begin
                    if (bad5 == 0) begin a5 = out_h[j]; e5 = in_h[i - 1056 * m]; end
                    bad5++;
                end
            end
        end
        chk(bad3 == 0, "R3", "branch 0 byte", a3, e3);
        if (m == 0) chk(bad2 == 0, "R4", "bypass byte", a2, e2);
        else        chk(bad2 == 0, "R2", "branch delay byte", a2, e2);
        chk(bad5 == 0, "R5", "deinterleaved byte", a5, e5);
        if (noise) chk(bad2 == 0, "R6", "depth noise ignored", bad2, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid during reset", out_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
        // R7: no depth ever loaded, so pass-through with noise on cfg_depth.
        run(0, 700, 15, 1'b0, 1'b1);
        // R2 R5 R8: smallest non-zero depth, with idle gaps.
        run(1, 1056 + 700, 20, 1'b1, 1'b0);
        // R6: same-depth reloads every frame, cfg_depth noise elsewhere.
        run(5, 5280 + 800, 10, 1'b1, 1'b1);
        // R2 R5: largest depth, back to back.
        run(31, 1056 * 31 + 400, 0, 1'b1, 1'b0);
        // R6: depth change clears offsets; stale bytes are not compared.
        run(2, 2112 + 500, 5, 1'b1, 1'b1);
        // R4: depth loaded back to zero.
        run(0, 600, 10, 1'b1, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule